// File: doc/BRIEF.md
# Single-Precision to 8-bit E4M3 Scale Encoder

This block turns a positive single-precision floating-point bit pattern into the 8-bit E4M3 code that is used to store block scale factors. It has 4 exponent bits with bias 7 and 3 mantissa bits. The encoder saturates at the largest finite code, 448.0, and rounds the mantissa to nearest with ties to even. A mantissa that rounds up past its field carries into the exponent. Small values go through a separate subnormal path, which rounds the input scaled by 512.

Every input falls into one of four classes:
- `CL_ZERO`: zero, or a single-precision subnormal.
- `CL_SUB`: below 2^-6.
- `CL_NORM`: from 2^-6 up to but not including 448.
- `CL_SAT`: 448 and above, and the all-ones exponent.

Each class selects one output case. With the default `PIPE_STAGE = 1`, a single register stage follows the encoder. A conversion presented with `in_valid` in one cycle then appears on `out_code` with `out_valid` one cycle later. In that mode the output code holds its last value while no new input arrives. With `PIPE_STAGE = 0` the path is combinational.

Top module: `fp8s_encoder`

## Requirements
- R1: Bit 31 of `in_bits` has no effect on `out_code`, and `out_code[7]` is always 0.
- R2: An input of 448.0 or more, or one with exponent field 255, gives 0x7E (exponent field 15, mantissa field 6). The code 0x7F is never produced.
- R3: An input whose exponent field is 0 (zero or a single-precision subnormal) gives 0x00.
- R4: For x in [2^-6, 448), `out_code[6:3]` = floor(log2 x) + 7 and `out_code[2:0]` = round((x / 2^floor(log2 x) - 1) * 8).
- R5: A value exactly halfway between two adjacent codes rounds to the one whose mantissa field is even.
- R6: When the rounded mantissa reaches 8, the output is the next exponent field with mantissa field 0.
- R7: For x < 2^-6, the exponent field is 0 and the mantissa field is round-to-nearest-even of x * 512, clamped to 7. So x in [7.5/512, 2^-6) gives 0x07, and x = 2^-10 gives 0x00.
- R8: With a register stage, `out_valid` equals `in_valid` of the previous cycle and `out_code` carries that cycle's result. While `in_valid` is low, `out_code` keeps its value.
- R9: During and directly after reset, `out_valid` is 0 and `out_code` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pattern is valid this cycle |
| in_bits | input | 32 | Single-precision bit pattern |
| out_valid | output | 1 | Result is valid |
| out_code | output | 8 | E4M3 code, sign bit always 0 |

## Verification
The bench drives every one of the 127 finite codes back in as an exact value and every midpoint between adjacent codes. An encoder with ties going away from zero shows up on half of those midpoints. One that drops the mantissa carry gives a mantissa field of 0 without the exponent step at the 0x?7/next boundary. It also probes values one unit in the last place (ulp) on either side of 448 and of 2^-6, where a wrong saturation compare would give 0x7F or a wrapped exponent. A design that sent the top subnormal band into the normal path would give 0x08 where the clamp asks for 0x07. Random patterns with both signs cover the remaining range and catch any leak of the input sign into the code.

// File: rtl/fp8s_pkg.sv
package fp8s_pkg;
    localparam int IN_EXP_W  = 8;
    localparam int IN_MAN_W  = 23;
    localparam int IN_W      = IN_EXP_W + IN_MAN_W + 1;
    localparam int IN_BIAS   = (1 << (IN_EXP_W - 1)) - 1;

    localparam int OUT_EXP_W = 4;
    localparam int OUT_MAN_W = 3;
    localparam int OUT_W     = OUT_EXP_W + OUT_MAN_W + 1;
    localparam int OUT_BIAS  = 7;

    localparam int OUT_EXP_MAX  = (1 << OUT_EXP_W) - 1;
    localparam int SAT_MANT     = (1 << OUT_MAN_W) - 2;
    localparam int EXP_OFFSET   = IN_BIAS - OUT_BIAS;
    localparam int SAT_EXP_IN   = IN_BIAS + OUT_EXP_MAX - OUT_BIAS;
    localparam int NORM_MIN_EXP = EXP_OFFSET + 1;
    localparam int SUB_MIN_EXP  = NORM_MIN_EXP - OUT_MAN_W - 1;
    localparam int SUB_W        = IN_MAN_W + 1 + OUT_MAN_W;

    typedef enum logic [1:0] {
        CL_ZERO = 2'd0,
        CL_SUB  = 2'd1,
        CL_NORM = 2'd2,
        CL_SAT  = 2'd3
    } fp8s_class_e;
endpackage

// File: rtl/fp8s_classify.sv
module fp8s_classify
    import fp8s_pkg::*;
(
    input  logic [IN_W-1:0]     in_bits,
    output fp8s_class_e         cls,
    output logic [IN_EXP_W-1:0] exp_f,
    output logic [IN_MAN_W-1:0] man_f
);
    logic                 unused_sign;
    logic [OUT_MAN_W-1:0] man_top;

    always_comb begin
        unused_sign = in_bits[IN_W-1];
        exp_f       = in_bits[IN_W-2 -: IN_EXP_W];
        man_f       = in_bits[IN_MAN_W-1:0];
        man_top     = man_f[IN_MAN_W-1 -: OUT_MAN_W];

        if (exp_f == '0)
            cls = CL_ZERO;
        else if ((exp_f > IN_EXP_W'(SAT_EXP_IN)) ||
                 ((exp_f == IN_EXP_W'(SAT_EXP_IN)) && (man_top >= OUT_MAN_W'(SAT_MANT))))
            cls = CL_SAT;
        else if (exp_f >= IN_EXP_W'(NORM_MIN_EXP))
            cls = CL_NORM;
        else
            cls = CL_SUB;
    end
endmodule

// File: rtl/fp8s_rne.sv
module fp8s_rne #(
    parameter int W_IN  = 23,
    parameter int W_OUT = 3
) (
    input  logic [W_IN-1:0] val,
    output logic [W_OUT:0]  rounded
);
    localparam int FRAC = W_IN - W_OUT;

    logic keep_lsb, guard, sticky, round_up;

    always_comb begin
        keep_lsb = val[FRAC];
        guard    = val[FRAC-1];
        sticky   = |val[FRAC-2:0];
        round_up = guard & (sticky | keep_lsb);
        rounded  = {1'b0, val[W_IN-1:FRAC]} + (W_OUT+1)'(round_up);
    end
endmodule

// File: rtl/fp8s_encode.sv
module fp8s_encode
    import fp8s_pkg::*;
(
    input  fp8s_class_e         cls,
    input  logic [IN_EXP_W-1:0] exp_f,
    input  logic [IN_MAN_W-1:0] man_f,
    output logic [OUT_W-1:0]    code
);
    logic [OUT_MAN_W:0]   norm_rnd;
    logic [OUT_MAN_W:0]   sub_rnd;
    logic [SUB_W-1:0]     sub_aligned;
    logic [IN_EXP_W-1:0]  sub_sh;
    logic [IN_EXP_W-1:0]  be_wide;
    logic [OUT_EXP_W-1:0] be;

    always_comb begin
        sub_sh = IN_EXP_W'(NORM_MIN_EXP - 1) - exp_f;
        if (exp_f < IN_EXP_W'(SUB_MIN_EXP))
            sub_aligned = '0;
        else
            sub_aligned = {1'b1, man_f, {OUT_MAN_W{1'b0}}} >> sub_sh;
    end

    fp8s_rne #(.W_IN(IN_MAN_W), .W_OUT(OUT_MAN_W)) u_norm_rne (
        .val     (man_f),
        .rounded (norm_rnd)
    );

    fp8s_rne #(.W_IN(SUB_W), .W_OUT(OUT_MAN_W)) u_sub_rne (
        .val     (sub_aligned),
        .rounded (sub_rnd)
    );

    always_comb begin
        be_wide = exp_f - IN_EXP_W'(EXP_OFFSET);
        be      = be_wide[OUT_EXP_W-1:0];
        unique case (cls)
            CL_ZERO: code = '0;
            CL_SAT:  code = {1'b0, OUT_EXP_W'(OUT_EXP_MAX), OUT_MAN_W'(SAT_MANT)};
            CL_NORM: begin
                if (norm_rnd[OUT_MAN_W])
                    code = {1'b0, be + OUT_EXP_W'(1), {OUT_MAN_W{1'b0}}};
                else
                    code = {1'b0, be, norm_rnd[OUT_MAN_W-1:0]};
            end
            CL_SUB: begin
                if (sub_rnd[OUT_MAN_W])
                    code = {1'b0, {OUT_EXP_W{1'b0}}, {OUT_MAN_W{1'b1}}};
                else
                    code = {1'b0, {OUT_EXP_W{1'b0}}, sub_rnd[OUT_MAN_W-1:0]};
            end
            default: code = '0;
        endcase
    end

    always_comb begin
        assert_sign_clear_R1: assert (code[OUT_W-1] == 1'b0);
        assert_no_nan_R2: assert (code[OUT_W-2:0] != {(OUT_W-1){1'b1}});
        if (cls == CL_NORM)
            assert_norm_exp_nonzero_R4: assert (code[OUT_W-2 -: OUT_EXP_W] != '0);
        if (cls == CL_SUB)
            assert_sub_exp_zero_R7: assert (code[OUT_W-2 -: OUT_EXP_W] == '0);
    end
endmodule

// File: rtl/fp8s_encoder.sv
module fp8s_encoder
    import fp8s_pkg::*;
#(
    parameter int PIPE_STAGE = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_bits,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_code
);
    fp8s_class_e         cls;
    logic [IN_EXP_W-1:0] exp_f;
    logic [IN_MAN_W-1:0] man_f;
    logic [OUT_W-1:0]    enc_code;

    fp8s_classify u_classify (
        .in_bits (in_bits),
        .cls     (cls),
        .exp_f   (exp_f),
        .man_f   (man_f)
    );

    fp8s_encode u_encode (
        .cls   (cls),
        .exp_f (exp_f),
        .man_f (man_f),
        .code  (enc_code)
    );

    generate
        if (PIPE_STAGE != 0) begin : g_reg
            logic             valid_q;
            logic [OUT_W-1:0] code_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    valid_q <= 1'b0;
                    code_q  <= '0;
                end else begin
                    valid_q <= in_valid;
                    if (in_valid)
                        code_q <= enc_code;
                end
            end

            assign out_valid = valid_q;
            assign out_code  = code_q;

            assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_valid == $past(in_valid)));
            assert_code_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(rst_n) && !$past(in_valid)) |-> $stable(out_code));
            assert_reset_clear_R9: assert property (@(posedge clk)
                $past(!rst_n) |-> (!out_valid && (out_code == '0)));
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_code  = enc_code;
        end
    endgenerate
endmodule

// File: tb/fp8s_encoder_tb.sv
module fp8s_encoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_bits = '0;
    logic        out_valid;
    logic [7:0]  out_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fp8s_encoder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_bits   (in_bits),
        .out_valid (out_valid),
        .out_code  (out_code)
    );

    function automatic real pow2(input int p);
        real r = 1.0;
        if (p >= 0) for (int i = 0; i < p; i++) r = r * 2.0;
        else for (int i = 0; i < -p; i++) r = r * 0.5;
        return r;
    endfunction

    function automatic int rne_real(input real v);
        real fl = $floor(v);
        real fr = v - fl;
        int  k  = int'(fl);
        if (fr > 0.5) k++;
        else if (fr == 0.5 && (k % 2) == 1) k++;
        return k;
    endfunction

    function automatic logic [7:0] ref_code(input logic [31:0] b);
        int  e, m, ex, bf;
        real x;
        e = int'(b[30:23]);
        if (e == 0) return 8'h00;
        if (e == 255) return 8'h7E;
        x = (1.0 + real'(b[22:0]) / 8388608.0) * pow2(e - 127);
        if (x >= 448.0) return 8'h7E;
        if (x < pow2(-6)) begin
            m = rne_real(x * 512.0);
            if (m > 7) m = 7;
            return {5'b0, m[2:0]};
        end
        ex = -6;
        while (x >= pow2(ex + 1)) ex++;
        m  = rne_real((x / pow2(ex) - 1.0) * 8.0);
        bf = ex + 7;
        if (m == 8) begin
            m = 0;
            bf++;
        end
        return {1'b0, bf[3:0], m[2:0]};
    endfunction

    // value k * 2^p as a positive single-precision pattern, k > 0
    function automatic logic [31:0] mk(input int k, input int p);
        int q = 0;
        int e;
        logic [31:0] mm;
        for (int i = 0; i < 31; i++) if (k >= (1 << i)) q = i;
        e  = q + p + 127;
        mm = 32'(k) << (23 - q);
        return {1'b0, e[7:0], mm[22:0]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic convert(input logic [31:0] b, input string req);
        logic [7:0] exp;
        exp = ref_code(b);
        @(negedge clk);
        in_valid = 1'b1;
        in_bits  = b;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R8", "valid after one cycle", 32'(out_valid), 32'd1);
        check(out_code == exp, req, $sformatf("code for %h", b), 32'(out_code), 32'(exp));
    endtask

    function automatic string code_req(input int c);
        if (c == 0) return "R3";
        if (c == 8'h7E) return "R2";
        if (c < 8) return "R7";
        return "R4";
    endfunction

    initial begin
        logic [31:0] r;
        logic [7:0]  held;
        int          seed_init;
        seed_init = $urandom(32'd20240611);

        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "valid in reset", 32'(out_valid), 32'd0);
        check(out_code == 8'h00, "R9", "code in reset", 32'(out_code), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9", "valid after reset", 32'(out_valid), 32'd0);
        check(out_code == 8'h00, "R9", "code after reset", 32'(out_code), 32'd0);

        // every finite code point
        for (int c = 1; c <= 8'h7E; c++) begin
            if (c < 8) convert(mk(c, -9), code_req(c));
            else convert(mk(8 + (c & 7), (c >> 3) - 10), code_req(c));
        end
        convert(32'h0000_0000, "R3");
        convert(32'h0000_0001, "R3");
        convert(32'h007F_FFFF, "R3");

        // midpoints between neighbouring codes (ties to even, carry)
        for (int c = 0; c < 8'h7E; c++) begin
            if (c < 8) convert(mk(2 * c + 1, -10), (c == 7) ? "R7" : "R5");
            else convert(mk(2 * (8 + (c & 7)) + 1, (c >> 3) - 11), ((c & 7) == 7) ? "R6" : "R5");
        end

        // saturation edges
        convert(32'h43E0_0000, "R2");
        convert(32'h43E0_0001, "R2");
        convert(32'h43DF_FFFF, "R2");
        convert(32'h43E8_0000, "R2");
        convert(32'h7F80_0000, "R2");
        convert(32'h7FC0_0000, "R2");
        convert(32'h7E96_7699, "R2");

        // normal / subnormal boundary
        convert(32'h3C80_0000, "R4");
        convert(32'h3C7F_FFFF, "R7");
        convert(32'h3C78_0000, "R7");
        convert(32'h3C77_FFFF, "R7");
        convert(32'h3A80_0000, "R7");
        convert(32'h3A80_0001, "R7");
        convert(32'h3A7F_FFFF, "R7");

        // sign ignored
        convert(32'hC3E0_0000, "R1");
        convert(32'hBF80_0000, "R1");
        convert(32'hBC7F_FFFF, "R1");

        // hold while idle
        convert(32'h3F80_0000, "R4");
        held = out_code;
        @(negedge clk);
        in_valid = 1'b0;
        in_bits  = 32'h4000_0000;
        @(negedge clk);
        check(out_valid == 1'b0, "R8", "valid low when idle", 32'(out_valid), 32'd0);
        check(out_code == held, "R8", "code held when idle", 32'(out_code), 32'(held));

        // random over the interesting exponent window, both signs
        for (int i = 0; i < 1500; i++) begin
            r = $urandom;
            r[30:23] = 8'(100 + ($urandom % 42));
            convert(r, r[31] ? "R1" : "R4");
        end
        for (int i = 0; i < 300; i++) begin
            r = $urandom;
            convert(r, "R2");
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule